// File: doc/BRIEF.md
# Fully Associative Two-Line Cache

This block sits between a processor load/store port and a byte-wide backing memory. It keeps a small number of lines (two by default), each holding a two-byte block, and compares the tag of every line in parallel on each access. A load or store that finds a valid line with a matching tag is a hit and is served from the line. On a miss the whole enclosing block is fetched from memory into a chosen line. The block then serves the access from that line. Stores that miss therefore allocate.

A parameter fixes the store policy at build time. In write-through mode every store is also written to memory. In write-back mode stores stay in the cache and mark the line dirty. A dirty line is copied back to memory only when it is chosen for replacement. The processor side accepts one access at a time and signals completion with a one-cycle response carrying hit status and data. Two running counters tally hits and misses. The memory side issues single-byte read or write requests and holds each one until the memory acknowledges it.

Top module: `assoc_cache`

## Requirements
- R1: After reset, the ready output is high, no response is pending, both counters read zero, and every line is invalid, so the first access to any block misses.
- R2: An access hits only when a valid line holds the tag, which is address bits [3:1]. A load hit returns the stored byte and makes no memory request.
- R3: A load miss reads both bytes of the enclosing block from memory, at offsets 0 then 1 under the requested tag. The response returns the byte at address bit 0. A memory request stays asserted, with a stable address, until the memory acknowledges it.
- R4: The fill target is the lowest-numbered invalid line when one exists, and otherwise the least-recently-used line. Load hits, store hits and fills all make the touched line the most recently used.
- R5: A store miss first fills the enclosing block and then writes the store byte into it. A later load sees the stored byte.
- R6: In write-through mode (WRITE_BACK=0), each store writes exactly one byte to memory at the store address, on both hits and misses. Nothing is ever written back on eviction.
- R7: In write-back mode (WRITE_BACK=1), a store changes only the cache and sets the line's dirty flag. A fill clears that flag. A store hit makes no memory request.
- R8: In write-back mode, a dirty victim's two bytes are written to memory under the victim's old tag before the fill reads begin. A clean victim is replaced without any memory write.
- R9: Each completed access adds one to exactly one of the two counters: the hit counter if it hit, the miss counter otherwise. The new value is visible in the cycle after the response.
- R10: Ready is low from the cycle after an access is accepted until the access finishes. Each access produces exactly one response, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor access request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data |
| req_ready_o | output | 1 | Block idle, request accepted |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_hit_o | output | 1 | Completed access was a hit |
| rsp_rdata_o | output | DATA_W | Byte at the accessed address |
| hit_count_o | output | CNT_W | Running hit total |
| miss_count_o | output | CNT_W | Running miss total |
| mem_req_o | output | 1 | Memory byte request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory accepted request; read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
Two functions can land in the same access. A store miss whose victim is dirty has to write the old block back and then allocate and modify the new block. A fill that finishes also updates the recency order that picks the next victim. The bench provokes both with a store to a block while the other line is recent, followed by misses that evict dirty lines. It runs the same accesses through a write-through and a write-back instance side by side. After every access it compares the memory image, the memory read and write totals, and the hit status of later accesses against a model built from the requirements.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_APPLY,
    ST_THRU,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/assoc_cache_store.sv
module assoc_cache_store #(
  parameter int NUM_LINES = 2,
  parameter int TAG_W     = 3,
  parameter int OFFS_W    = 1,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [IDX_W-1:0]  victim_idx_o,
  output logic              victim_valid_o,
  output logic              victim_dirty_o,
  output logic [TAG_W-1:0]  victim_tag_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFFS_W-1:0] wr_offs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dirty_i,
  input  logic              install_en_i,
  input  logic [TAG_W-1:0]  install_tag_i,
  input  logic              touch_en_i,
  input  logic [IDX_W-1:0]  touch_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFFS_W-1:0] rd_offs_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int BLK_BYTES = 1 << OFFS_W;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] valid_q, dirty_q, hit_vec;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [IDX_W-1:0]     age_q  [NUM_LINES];
  logic [DATA_W-1:0]    data_q [NUM_LINES][BLK_BYTES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_tag_i);

    // R7
    dirty_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[g] |-> valid_q[g]);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
  end

  // invalid line first (lowest index), else the oldest
  always_comb begin
    logic found;
    found        = 1'b0;
    victim_idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (!found && !valid_q[i]) begin
        victim_idx_o = IDX_W'(i);
        found        = 1'b1;
      end
    if (!found)
      for (int i = 0; i < NUM_LINES; i++)
        if (age_q[i] == OLDEST) victim_idx_o = IDX_W'(i);
  end

  assign victim_valid_o = valid_q[victim_idx_o];
  assign victim_dirty_o = dirty_q[victim_idx_o];
  assign victim_tag_o   = tag_q[victim_idx_o];
  assign rd_data_o      = data_q[rd_idx_i][rd_offs_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= IDX_W'(i);
        for (int b = 0; b < BLK_BYTES; b++) data_q[i][b] <= '0;
      end
    end else begin
      if (install_en_i) begin
        tag_q[wr_idx_i]   <= install_tag_i;
        valid_q[wr_idx_i] <= 1'b1;
        dirty_q[wr_idx_i] <= 1'b0;
      end
      if (wr_en_i) begin
        data_q[wr_idx_i][wr_offs_i] <= wr_data_i;
        if (wr_dirty_i) dirty_q[wr_idx_i] <= 1'b1;
      end
      if (touch_en_i)
        for (int i = 0; i < NUM_LINES; i++) begin
          if (IDX_W'(i) == touch_idx_i)             age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx_i])   age_q[i] <= age_q[i] + 1'b1;
        end
    end
  end

  // R2
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
  import assoc_cache_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int OFFS_W     = 1,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 1,
  parameter bit WRITE_BACK = 1'b0,
  localparam int TAG_W     = ADDR_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [IDX_W-1:0]  victim_idx_i,
  input  logic              victim_valid_i,
  input  logic              victim_dirty_i,
  input  logic [TAG_W-1:0]  victim_tag_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [OFFS_W-1:0] wr_offs_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_dirty_o,
  output logic              install_en_o,
  output logic [TAG_W-1:0]  install_tag_o,
  output logic              touch_en_o,
  output logic [IDX_W-1:0]  touch_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [OFFS_W-1:0] rd_offs_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [OFFS_W-1:0] LAST_OFFS = '1;

  seq_state_e        state_q, state_d;
  logic              we_q, hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  line_q;
  logic [TAG_W-1:0]  vtag_q;
  logic [OFFS_W-1:0] cnt_q;
  logic [OFFS_W-1:0] offs;
  logic              after_store;

  assign lk_tag_o      = addr_q[ADDR_W-1:OFFS_W];
  assign offs          = addr_q[OFFS_W-1:0];
  assign install_tag_o = lk_tag_o;
  assign wr_dirty_o    = wr_en_o && WRITE_BACK && (state_q != ST_FILL);
  assign after_store   = we_q && !WRITE_BACK;
  assign rsp_hit_o     = rsp_valid_o && hit_q;
  assign rsp_rdata_o   = rsp_valid_o ? rd_data_i : '0;

  always_comb begin
    state_d      = state_q;
    req_ready_o  = 1'b0;
    rsp_valid_o  = 1'b0;
    wr_en_o      = 1'b0;
    wr_idx_o     = line_q;
    wr_offs_o    = offs;
    wr_data_o    = wdata_q;
    install_en_o = 1'b0;
    touch_en_o   = 1'b0;
    touch_idx_o  = line_q;
    rd_idx_o     = line_q;
    rd_offs_o    = offs;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = addr_q;
    mem_wdata_o  = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit_i) begin
          touch_en_o  = 1'b1;
          touch_idx_o = hit_idx_i;
          wr_en_o     = we_q;
          wr_idx_o    = hit_idx_i;
          state_d     = after_store ? ST_THRU : ST_DONE;
        end else begin
          state_d = (WRITE_BACK && victim_valid_i && victim_dirty_i) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {vtag_q, cnt_q};
        rd_offs_o   = cnt_q;
        mem_wdata_o = rd_data_i;
        if (mem_ack_i && cnt_q == LAST_OFFS) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {lk_tag_o, cnt_q};
        if (mem_ack_i) begin
          wr_en_o   = 1'b1;
          wr_offs_o = cnt_q;
          wr_data_o = mem_rdata_i;
          if (cnt_q == LAST_OFFS) begin
            install_en_o = 1'b1;
            touch_en_o   = 1'b1;
            state_d      = ST_APPLY;
          end
        end
      end
      ST_APPLY: begin
        wr_en_o = we_q;
        state_d = after_store ? ST_THRU : ST_DONE;
      end
      ST_THRU: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) state_d = ST_DONE;
      end
      ST_DONE: begin
        rsp_valid_o = 1'b1;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      line_q  <= '0;
      vtag_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        we_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_LOOKUP) begin
        hit_q  <= hit_i;
        line_q <= hit_i ? hit_idx_i : victim_idx_i;
        vtag_q <= victim_tag_i;
        cnt_q  <= '0;
      end
      if ((state_q == ST_EVICT || state_q == ST_FILL) && mem_ack_i)
        cnt_q <= (cnt_q == LAST_OFFS) ? '0 : cnt_q + 1'b1;
    end
  end

  // R10
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R10
  busy_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/assoc_cache_counters.sv
module assoc_cache_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] miss_count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_count_o  <= '0;
      miss_count_o <= '0;
    end else if (done_i) begin
      if (hit_i) hit_count_o  <= hit_count_o + 1'b1;
      else       miss_count_o <= miss_count_o + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache #(
  parameter int NUM_LINES  = 2,
  parameter int ADDR_W     = 4,
  parameter int OFFS_W     = 1,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int TAG_W = ADDR_W - OFFS_W;
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [TAG_W-1:0]  lk_tag, victim_tag, install_tag;
  logic              hit, victim_valid, victim_dirty;
  logic [IDX_W-1:0]  hit_idx, victim_idx, wr_idx, touch_idx, rd_idx;
  logic              wr_en, wr_dirty, install_en, touch_en;
  logic [OFFS_W-1:0] wr_offs, rd_offs;
  logic [DATA_W-1:0] wr_data, rd_data;

  assoc_cache_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .OFFS_W(OFFS_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_store (
    .clk_i, .rst_ni,
    .lk_tag_i(lk_tag), .hit_o(hit), .hit_idx_o(hit_idx),
    .victim_idx_o(victim_idx), .victim_valid_o(victim_valid),
    .victim_dirty_o(victim_dirty), .victim_tag_o(victim_tag),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_offs_i(wr_offs),
    .wr_data_i(wr_data), .wr_dirty_i(wr_dirty),
    .install_en_i(install_en), .install_tag_i(install_tag),
    .touch_en_i(touch_en), .touch_idx_i(touch_idx),
    .rd_idx_i(rd_idx), .rd_offs_i(rd_offs), .rd_data_o(rd_data)
  );

  assoc_cache_ctrl #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WRITE_BACK(WRITE_BACK)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .req_ready_o, .rsp_valid_o, .rsp_hit_o, .rsp_rdata_o,
    .lk_tag_o(lk_tag), .hit_i(hit), .hit_idx_i(hit_idx),
    .victim_idx_i(victim_idx), .victim_valid_i(victim_valid),
    .victim_dirty_i(victim_dirty), .victim_tag_i(victim_tag),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_offs_o(wr_offs),
    .wr_data_o(wr_data), .wr_dirty_o(wr_dirty),
    .install_en_o(install_en), .install_tag_o(install_tag),
    .touch_en_o(touch_en), .touch_idx_o(touch_idx),
    .rd_idx_o(rd_idx), .rd_offs_o(rd_offs), .rd_data_i(rd_data),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i
  );

  assoc_cache_counters #(.CNT_W(CNT_W)) i_counters (
    .clk_i, .rst_ni,
    .done_i(rsp_valid_o), .hit_i(rsp_hit_o),
    .hit_count_o, .miss_count_o
  );

  logic [CNT_W:0] count_sum;
  assign count_sum = {1'b0, hit_count_o} + {1'b0, miss_count_o};

  // R9
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> count_sum == $past(count_sum) + 1'b1);
endmodule

// File: tb/test_assoc_cache.sv
module test_assoc_cache;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       hit;
    logic [7:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;

  logic        req_ready [2], rsp_valid [2], rsp_hit [2];
  logic [7:0]  rsp_rdata [2];
  logic [15:0] hit_cnt [2], miss_cnt [2];
  logic        mem_req [2], mem_we [2], mem_ack [2];
  logic [3:0]  mem_addr [2];
  logic [7:0]  mem_wdata [2], mem_rdata [2];

  logic [7:0] act_mem [2][16];
  int         act_wr [2], act_rd [2], rsp_seen [2];

  int n_checks = 0, n_err = 0, n_acc = 0;
  bit finished = 1'b0;
  exp_t q0[$], q1[$];

  // reference state
  logic [7:0] exp_mem [2][16];
  bit         mv [2][2], md [2][2];
  logic [2:0] mtag [2][2];
  logic [7:0] mdat [2][2][2];
  int         mlru [2];
  int         ehit [2], emiss [2], exp_wr [2], exp_rd [2];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    assoc_cache #(.WRITE_BACK(m)) i_assoc_cache (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .req_ready_o(req_ready[m]), .rsp_valid_o(rsp_valid[m]),
      .rsp_hit_o(rsp_hit[m]), .rsp_rdata_o(rsp_rdata[m]),
      .hit_count_o(hit_cnt[m]), .miss_count_o(miss_cnt[m]),
      .mem_req_o(mem_req[m]), .mem_we_o(mem_we[m]),
      .mem_addr_o(mem_addr[m]), .mem_wdata_o(mem_wdata[m]),
      .mem_ack_i(mem_ack[m]), .mem_rdata_i(mem_rdata[m])
    );

    // backing memory: acks every other cycle
    initial begin
      mem_ack[m]   = 1'b0;
      mem_rdata[m] = '0;
      act_wr[m]    = 0;
      act_rd[m]    = 0;
      for (int i = 0; i < 16; i++) act_mem[m][i] = 8'(16 * i + 5);
      forever begin
        @(negedge clk);
        if (mem_req[m] && !mem_ack[m]) begin
          mem_ack[m] = 1'b1;
          if (mem_we[m]) begin
            act_mem[m][mem_addr[m]] = mem_wdata[m];
            act_wr[m]++;
          end else begin
            mem_rdata[m] = act_mem[m][mem_addr[m]];
            act_rd[m]++;
          end
        end else begin
          mem_ack[m] = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_access(input int m, input bit we, input logic [3:0] addr,
                              input logic [7:0] wd, output exp_t e);
    logic [2:0] tag;
    int         off, idx;
    bit         hit;
    tag = addr[3:1];
    off = int'(addr[0]);
    hit = 1'b0;
    idx = 0;
    for (int l = 0; l < 2; l++)
      if (mv[m][l] && mtag[m][l] == tag) begin hit = 1'b1; idx = l; end
    if (!hit) begin
      if (!mv[m][0])      idx = 0;
      else if (!mv[m][1]) idx = 1;
      else                idx = mlru[m];
      if (m == 1 && mv[m][idx] && md[m][idx]) begin
        for (int b = 0; b < 2; b++) exp_mem[m][{mtag[m][idx], 1'(b)}] = mdat[m][idx][b];
        exp_wr[m] += 2;
      end
      for (int b = 0; b < 2; b++) mdat[m][idx][b] = exp_mem[m][{tag, 1'(b)}];
      exp_rd[m] += 2;
      mv[m][idx]   = 1'b1;
      md[m][idx]   = 1'b0;
      mtag[m][idx] = tag;
    end
    mlru[m] = 1 - idx;
    if (we) begin
      mdat[m][idx][off] = wd;
      if (m == 1) md[m][idx] = 1'b1;
      else begin
        exp_mem[m][addr] = wd;
        exp_wr[m]++;
      end
    end
    if (hit) ehit[m]++; else emiss[m]++;
    e.hit  = hit;
    e.data = mdat[m][idx][off];
  endtask

  task automatic access(input bit we, input logic [3:0] addr, input logic [7:0] wd,
                        input string req);
    exp_t e;
    bit   same;
    model_access(0, we, addr, wd, e); q0.push_back(e);
    model_access(1, we, addr, wd, e); q1.push_back(e);
    n_acc++;
    while (!(req_ready[0] && req_ready[1])) @(negedge clk);
    req_valid = 1'b1;
    req_write = we;
    req_addr  = addr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(req_ready[0] && req_ready[1])) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      same = 1'b1;
      for (int i = 0; i < 16; i++) if (act_mem[m][i] !== exp_mem[m][i]) same = 1'b0;
      check(same, {req, " memory image"}, m, m);
      check(act_wr[m] == exp_wr[m], {req, " memory writes"}, act_wr[m], exp_wr[m]);
      check(act_rd[m] == exp_rd[m], {req, " memory reads"}, act_rd[m], exp_rd[m]);
      // R9
      check(hit_cnt[m] == 16'(ehit[m]), "R9 hit counter", int'(hit_cnt[m]), ehit[m]);
      check(miss_cnt[m] == 16'(emiss[m]), "R9 miss counter", int'(miss_cnt[m]), emiss[m]);
      // R10
      check(rsp_seen[m] == n_acc, "R10 one response per access", rsp_seen[m], n_acc);
    end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    rsp_seen[0] = 0;
    rsp_seen[1] = 0;
    forever begin
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        if (rst_n && rsp_valid[m]) begin
          rsp_seen[m]++;
          if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
            check(1'b0, "R10 unexpected response", m, -1);
          end else begin
            e = (m == 0) ? q0.pop_front() : q1.pop_front();
            check(rsp_hit[m] == e.hit, "R2 R4 hit status", int'(rsp_hit[m]), int'(e.hit));
            check(rsp_rdata[m] == e.data, "R3 R5 response data", int'(rsp_rdata[m]), int'(e.data));
          end
        end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) exp_mem[m][i] = 8'(16 * i + 5);
      for (int l = 0; l < 2; l++) begin mv[m][l] = 0; md[m][l] = 0; mtag[m][l] = '0; end
      mlru[m] = 0; ehit[m] = 0; emiss[m] = 0; exp_wr[m] = 0; exp_rd[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // R1
      check(req_ready[m] == 1'b1, "R1 ready after reset", int'(req_ready[m]), 1);
      check(rsp_valid[m] == 1'b0, "R1 no response after reset", int'(rsp_valid[m]), 0);
      check(hit_cnt[m] == 0 && miss_cnt[m] == 0, "R1 counters zero",
            int'(hit_cnt[m]) + int'(miss_cnt[m]), 0);
    end
    access(0, 4'd1,  8'h00, "R1 R3 cold load");
    access(0, 4'd5,  8'h00, "R4 fill second line");
    access(0, 4'd1,  8'h00, "R2 load hit");
    access(0, 4'd4,  8'h00, "R2 load hit other offset");
    access(0, 4'd0,  8'h00, "R4 recency refresh");
    access(1, 4'd0,  8'hAA, "R6 R7 store hit");
    access(1, 4'd5,  8'hBB, "R6 R7 store hit second line");
    access(0, 4'd10, 8'h00, "R8 dirty eviction on load miss");
    access(1, 4'd13, 8'hCC, "R5 R8 store miss with dirty victim");
    access(0, 4'd0,  8'h00, "R8 written-back data reloads");
    access(0, 4'd13, 8'h00, "R5 stored byte visible");
    access(0, 4'd7,  8'h00, "R4 clean victim replaced");
    access(1, 4'd7,  8'h11, "R7 store hit no traffic");
    access(1, 4'd7,  8'h22, "R6 R7 repeated store");
    access(0, 4'd2,  8'h00, "R8 eviction after repeated stores");
    access(0, 4'd14, 8'h00, "R3 load miss upper block");
    access(0, 4'd6,  8'h00, "R8 evicted block reloads");
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++)
      check(q0.size() + q1.size() == 0, "R10 all responses seen", q0.size() + q1.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule